// File: doc/BRIEF.md
# Nibble-Packed Pixel RAM Port

This block sits between a processor and a 16-bit-wide backing RAM and treats every stored word as four 4-bit pixels. Pixel 0 lives in the top nibble of the word and pixel 3 in the bottom nibble. A byte write from the processor changes exactly one pixel. The two low address bits pick the pixel, and a 2-bit priority mode decides whether the write lands at all. A word read returns two neighbouring pixels, each zero-extended into its own byte.

The backing store is interleaved between two banks. The port always addresses the even-indexed words, at index `(address >> 1)` with bit 0 forced to zero. The RAM has no nibble enables, so every pixel write is a read-modify-write: one cycle fetches the old word and the next cycle writes the merged word back. While that is in progress the port raises `busy` and ignores new strobes. When the owning logic has not assigned a bank to this port (`bank_valid` low), reads return all ones and writes vanish without touching the RAM.

Top module: `pixram_port`

## Requirements
- R1: During and directly after reset, `busy`, `rd_valid`, `mem_re` and `mem_we` are 0 and `rd_word` is 0x0000.
- R2: A word read at an address with bit 1 set returns stored bits [7:4] in result bits [11:8] and stored bits [3:0] in result bits [3:0]. Result bits [15:12] and [7:4] are zero.
- R3: A word read at an address with bit 1 clear returns stored bits [15:12] in result bits [11:8] and stored bits [11:8] in result bits [3:0]. Result bits [15:12] and [7:4] are zero. The word read or written is always RAM index `{address[ADDR_W-1:2], 1'b0}`.
- R4: In priority mode 0 or 3 (normal), a pixel write stores `wr_byte[3:0]` into bits [15-4*s : 12-4*s] of the word, where s = address[1:0]. The other three nibbles are preserved and `wr_byte[7:4]` has no effect.
- R5: In priority mode 2 (overwrite), a pixel value of zero leaves the word unchanged, and a nonzero value is stored as in R4.
- R6: In priority mode 1 (underwrite), a pixel value of zero leaves the word unchanged. A nonzero value is stored as in R4 only when the addressed nibble currently holds zero; otherwise the word is unchanged.
- R7: With `bank_valid` low, a read strobe returns 0xFFFF with `rd_valid` one cycle after the sampling edge, and a write strobe issues no RAM access.
- R8: With a bank present, a strobe sampled at edge k raises `busy` for exactly two cycles. A read's `rd_valid` pulses after edge k+2 and the RAM write follows edge k+2. Strobes sampled while `busy` is high are ignored, and a read strobe wins over a simultaneous write strobe.
- R9: Every RAM access uses an even word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_valid | input | 1 | A bank is currently assigned to this port |
| prio_mode | input | 2 | 0/3 normal, 1 underwrite, 2 overwrite |
| cpu_addr | input | ADDR_W | Processor byte address |
| rd_stb | input | 1 | Word read request |
| wr_stb | input | 1 | Pixel byte write request |
| wr_byte | input | 8 | Write data; low nibble is the pixel |
| rd_word | output | 16 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse: `rd_word` is fresh |
| busy | output | 1 | Access in progress, strobes ignored |
| mem_addr | output | ADDR_W-1 | RAM word index |
| mem_re | output | 1 | RAM read enable (data next cycle) |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after `mem_re` |

## Verification
A wrong lane decode or a broken merge corrupts a neighbouring pixel, and the damage shows in the RAM word written back two cycles after the strobe. The bench compares that word against its own model after every write. A wrong priority decision either stores a pixel that should have been discarded or drops one that should have landed, and the next RAM comparison catches it. A stuck or mistimed control state shows up on `busy` and `rd_valid` inside the same access, because the bench checks both at each cycle of every transaction.

// File: rtl/pixram_pkg.sv
package pixram_pkg;
  typedef enum logic [1:0] {
    PRIO_PLAIN     = 2'd0,
    PRIO_UNDER     = 2'd1,
    PRIO_OVER      = 2'd2,
    PRIO_PLAIN_ALT = 2'd3
  } prio_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_APPLY = 2'd2
  } st_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/pixram_merge.sv
module pixram_merge
  import pixram_pkg::*;
#(
  parameter int unsigned PIX_W = 4,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned WORD_W = PIX_W * LANES
) (
  input  logic [WORD_W-1:0] old_word,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PIX_W-1:0]  pix,
  input  prio_e             mode,
  output logic [WORD_W-1:0] new_word,
  output logic              commit
);
  logic [LANES-1:0] hit;
  logic [PIX_W-1:0] old_pix;

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign hit[p] = (sel == SEL_W'(p));
    assign new_word[WORD_W-1-PIX_W*p -: PIX_W] =
      hit[p] ? pix : old_word[WORD_W-1-PIX_W*p -: PIX_W];
  end

  always_comb begin
    old_pix = '0;
    for (int p = 0; p < LANES; p++) begin
      if (hit[p]) old_pix = old_word[WORD_W-1-PIX_W*p -: PIX_W];
    end
  end

  always_comb begin
    case (mode)
      PRIO_UNDER: commit = (pix != '0) && (old_pix == '0);
      PRIO_OVER:  commit = (pix != '0);
      default:    commit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pixram_unpack.sv
module pixram_unpack
  import pixram_pkg::*;
#(
  parameter int unsigned PIX_W = 4,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned WORD_W = PIX_W * LANES
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [SEL_W-2:0]  half,
  output logic [WORD_W-1:0] pair_out
);
  logic [PIX_W-1:0] hi_pix, lo_pix;
  logic [SEL_W-1:0] hi_idx, lo_idx;

  assign hi_idx = {half, 1'b0};
  assign lo_idx = {half, 1'b1};

  always_comb begin
    hi_pix = '0;
    lo_pix = '0;
    for (int p = 0; p < LANES; p++) begin
      if (hi_idx == SEL_W'(p)) hi_pix = word_in[WORD_W-1-PIX_W*p -: PIX_W];
      if (lo_idx == SEL_W'(p)) lo_pix = word_in[WORD_W-1-PIX_W*p -: PIX_W];
    end
  end

  assign pair_out = {{PIX_W{1'b0}}, hi_pix, {PIX_W{1'b0}}, lo_pix};
endmodule

// File: rtl/pixram_ctrl.sv
module pixram_ctrl
  import pixram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned PIX_W  = 4,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned BYTE_W = 2 * PIX_W,
  localparam int unsigned MEM_AW = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_valid,
  input  logic [1:0]        prio_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] merged,
  input  logic              commit,
  input  logic [WORD_W-1:0] unpacked,
  output logic [SEL_W-1:0]  cap_sel,
  output logic [PIX_W-1:0]  cap_pix,
  output prio_e             cap_mode,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              busy,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata
);
  st_e  state;
  logic cap_rd;
  logic unused_hi;

  assign unused_hi = ^wr_byte[BYTE_W-1:PIX_W];
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cap_rd    <= 1'b0;
      cap_sel   <= '0;
      cap_pix   <= '0;
      cap_mode  <= PRIO_PLAIN;
      rd_word   <= '0;
      rd_valid  <= 1'b0;
      mem_addr  <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      rd_valid <= 1'b0;
      mem_re   <= 1'b0;
      mem_we   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rd_stb || wr_stb) begin
            if (bank_valid) begin
              cap_rd   <= rd_stb;
              cap_sel  <= cpu_addr[SEL_W-1:0];
              cap_pix  <= wr_byte[PIX_W-1:0];
              cap_mode <= prio_e'(prio_mode);
              mem_addr <= {cpu_addr[ADDR_W-1:SEL_W], {(SEL_W-1){1'b0}}};
              mem_re   <= 1'b1;
              state    <= ST_FETCH;
            end else if (rd_stb) begin
              rd_word  <= '1;
              rd_valid <= 1'b1;
            end
          end
        end
        ST_FETCH: state <= ST_APPLY;
        ST_APPLY: begin
          state <= ST_IDLE;
          if (cap_rd) begin
            rd_word  <= unpacked;
            rd_valid <= 1'b1;
          end else if (commit) begin
            mem_we    <= 1'b1;
            mem_wdata <= merged;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  function automatic logic [WORD_W-1:0] lane_mask(input logic [SEL_W-1:0] s);
    lane_mask = {{PIX_W{1'b1}}, {(WORD_W-PIX_W){1'b0}}} >> (PIX_W * s);
  endfunction

  function automatic logic [PIX_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                               input logic [SEL_W-1:0] s);
    lane_of = PIX_W'((w & lane_mask(s)) >> (WORD_W - PIX_W - PIX_W * s));
  endfunction

  // R9
  even_index_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> (mem_addr[0] == 1'b0));

  // R8
  write_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re, 2));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 !busy);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !busy);

  // R7
  nobank_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> $past(bank_valid));

  // R4
  keep_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata & ~lane_mask(cap_sel)) ==
                ($past(mem_rdata) & ~lane_mask(cap_sel))));

  // R5
  no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (cap_mode == PRIO_OVER || cap_mode == PRIO_UNDER))
      |-> (lane_of(mem_wdata, cap_sel) != '0));

  // R6
  under_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cap_mode == PRIO_UNDER) |-> (lane_of($past(mem_rdata), cap_sel) == '0));
endmodule

// File: rtl/pixram_port.sv
module pixram_port
  import pixram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned PIX_W  = 4,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned WORD_W = PIX_W * LANES,
  localparam int unsigned BYTE_W = 2 * PIX_W,
  localparam int unsigned MEM_AW = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_valid,
  input  logic [1:0]        prio_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              busy,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [SEL_W-1:0]  cap_sel;
  logic [PIX_W-1:0]  cap_pix;
  prio_e             cap_mode;
  logic [WORD_W-1:0] merged, unpacked;
  logic              commit;

  pixram_ctrl #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst(rst), .bank_valid(bank_valid), .prio_mode(prio_mode),
    .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .mem_rdata(mem_rdata), .merged(merged), .commit(commit), .unpacked(unpacked),
    .cap_sel(cap_sel), .cap_pix(cap_pix), .cap_mode(cap_mode),
    .rd_word(rd_word), .rd_valid(rd_valid), .busy(busy),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  pixram_merge #(.PIX_W(PIX_W)) u_merge (
    .old_word(mem_rdata), .sel(cap_sel), .pix(cap_pix), .mode(cap_mode),
    .new_word(merged), .commit(commit)
  );

  pixram_unpack #(.PIX_W(PIX_W)) u_unpack (
    .word_in(mem_rdata), .half(cap_sel[SEL_W-1:1]), .pair_out(unpacked)
  );
endmodule

// File: tb/pixram_port_bench.sv
`timescale 1ns/1ps
module pixram_port_bench;
  localparam int AW = 6;
  localparam int NW = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank_valid = 1'b1;
  logic [1:0] prio_mode = 2'd0;
  logic [AW-1:0] cpu_addr = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [15:0] rd_word, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic rd_valid, busy, mem_re, mem_we;
  logic [AW-2:0] mem_addr;

  logic [15:0] ram [NW];
  logic [15:0] model [NW];
  int nvec = 0, nfail = 0, we_cnt = 0;

  always #2 clk = ~clk;

  pixram_port #(.ADDR_W(AW), .PIX_W(4)) u_pixram_port (
    .clk(clk), .rst(rst), .bank_valid(bank_valid), .prio_mode(prio_mode),
    .cpu_addr(cpu_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_word(rd_word), .rd_valid(rd_valid), .busy(busy),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < NW; i++) begin ram[i] = '0; model[i] = '0; end

  always @(posedge clk) begin
    if (mem_we) begin ram[mem_addr] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input int a);
    return (a >> 1) & ~1;
  endfunction

  function automatic logic [15:0] exp_pair(input logic [15:0] w, input int a);
    if ((a & 2) != 0) return {4'h0, w[7:4], 4'h0, w[3:0]};
    return {4'h0, w[15:12], 4'h0, w[11:8]};
  endfunction

  function automatic logic [15:0] exp_write(input logic [15:0] w, input int a,
                                            input int mode, input int b);
    int v = b & 15;
    int sh = 12 - 4 * (a & 3);
    int old = (w >> sh) & 15;
    if (mode == 2 && v == 0) return w;
    if (mode == 1 && (v == 0 || old != 0)) return w;
    return (w & ~(16'hF << sh)) | 16'(v << sh);
  endfunction

  function automatic string tag_of(input int mode);
    if (mode == 1) return "R6";
    if (mode == 2) return "R5";
    return "R4";
  endfunction

  task automatic do_write(input int a, input int mode, input int b);
    int i = idx_of(a);
    int w0 = we_cnt;
    @(negedge clk);
    cpu_addr = AW'(a); prio_mode = 2'(mode); wr_byte = 8'(b); wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (!bank_valid) begin
      chk("R7 busy", busy, 0);
      repeat (3) @(negedge clk);
      chk("R7 no write", we_cnt - w0, 0);
      return;
    end
    chk("R8 busy1", busy, 1);
    @(negedge clk);
    chk("R8 busy2", busy, 1);
    @(negedge clk);
    chk("R8 busy end", busy, 0);
    model[i] = exp_write(model[i], a, mode, b);
    @(negedge clk);
    chk(tag_of(mode), ram[i], model[i]);
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    cpu_addr = AW'(a); rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    if (!bank_valid) begin
      chk("R7 valid", rd_valid, 1);
      chk("R7 data", rd_word, 16'hFFFF);
      return;
    end
    chk("R8 early", rd_valid, 0);
    @(negedge clk);
    chk("R8 early2", rd_valid, 0);
    @(negedge clk);
    chk("R8 valid", rd_valid, 1);
    chk((a & 2) != 0 ? "R2" : "R3", rd_word, exp_pair(model[idx_of(a)], a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 valid", rd_valid, 0);
    chk("R1 memctl", {mem_re, mem_we}, 0);
    chk("R1 data", rd_word, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", {busy, rd_valid, mem_re, mem_we}, 0);

    // R4 directed: pixel 1 of word 0, upper bits of the byte ignored
    do_write(1, 0, 8'hF7);
    do_read(0);
    do_read(2);
    // R5 directed: zero discarded in overwrite
    do_write(1, 2, 8'h50);
    // R6 directed: occupied nibble not replaced, empty nibble filled
    do_write(1, 1, 8'h03);
    do_write(3, 1, 8'h09);
    // R9 and R3: addresses 4..7 map to word index 2
    do_write(6, 3, 8'h0C);
    do_read(4);

    // near-exhaustive sweep over addresses, modes and pixel values
    for (int pass = 0; pass < 2; pass++)
      for (int a = 0; a < (1 << AW); a++)
        for (int k = 0; k < 8; k++)
          do_write(a, (k + a + pass) % 4, (((a ^ k) & 15) << 4) | ((k * 5 + a * 3 + pass) % 16));
    for (int a = 0; a < (1 << AW); a++) do_read(a);

    // R8: strobe while busy is ignored, read wins over write
    @(negedge clk);
    cpu_addr = AW'(8); rd_stb = 1'b1; wr_stb = 1'b1; wr_byte = 8'h05; prio_mode = 2'd0;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b1; cpu_addr = AW'(12);
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
    chk("R8 rd wins", rd_word, exp_pair(model[idx_of(8)], 8));
    repeat (2) @(negedge clk);
    chk("R8 ignored", ram[idx_of(12)], model[idx_of(12)]);
    chk("R8 no merge", ram[idx_of(8)], model[idx_of(8)]);

    // R7: no bank
    bank_valid = 1'b0;
    do_read(0);
    do_write(0, 0, 8'h0A);
    chk("R7 storage", ram[0], model[0]);
    bank_valid = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule